// File: doc/BRIEF.md
# Oversampled UART Receiver with Flow-Controlled Receive Queue

This block is the receive half of an asynchronous serial port. A 16x-oversampled receiver checks and frames each incoming character and writes it, with three per-character error flags, into a 16-entry first-in first-out queue. The host reads the queue one entry at a time. The entry at the head is always visible on the output pins, and a one-cycle pop strobe moves to the next entry. The host also sees the queue occupancy and a sticky overrun flag.

The block drives an active-low request-to-send output so that the remote transmitter can be paused before the queue overflows. A two-bit threshold select sets when the output is withdrawn. At the three lower thresholds the output is withdrawn once the occupancy reaches the threshold, and it comes back only after the host has emptied the queue. At the highest threshold the output is withdrawn in the middle of the character that would fill the last free entry, and it comes back as soon as the host frees one entry. When automatic flow control is off, the output simply mirrors the host's manual request bit.

The baud divider is outside this block. It supplies `baud_tick`, a one-cycle enable at sixteen times the bit rate.

Top module: `uart_rx_rtsq`

## Requirements
- R1: After reset the queue is empty (`rx_level` = 0), `overrun` is 0, and `rts_n` equals the inverse of `rts_request`.
- R2: Data bits arrive least-significant bit first. `char_len` selects 5, 6, 7 or 8 data bits (encodings 00, 01, 10, 11), and the received value is right-aligned in `rx_data` with the unused upper bits set to 0.
- R3: When `parity_en` is 1, the bit after the data is checked. `parity_odd` = 0 requires an even number of ones across data and parity, and 1 requires an odd number. A mismatch sets `rx_perr` for that entry. When `parity_en` is 0, no parity bit is expected and `rx_perr` is 0.
- R4: A stop bit sampled low sets `rx_ferr` for that entry.
- R5: A character whose data, parity and stop samples are all low is stored with both `rx_brk` and `rx_ferr` set. While the line then stays low, no further character is accepted.
- R6: Each bit is sampled on the 8th baud tick of its 16. A start bit that is back high at its 8th tick is discarded and no entry is written.
- R7: The queue holds 16 entries and returns them in arrival order. The head is presented without a read latency. A pop while the queue is empty changes nothing.
- R8: A character that completes while the queue holds 16 entries is dropped and sets `overrun`. `overrun` stays set until `status_rd` is pulsed.
- R9: With `flow_auto` = 1 and `rts_request` = 1, and with a threshold of 1, 4 or 8, `rts_n` goes high once `rx_level` reaches the threshold. It returns low only when `rx_level` has fallen to 0.
- R10: With the threshold at 14, `rts_n` goes high when the first data bit of a character is sampled while 15 entries are held. It returns low after the next pop.
- R11: With `flow_auto` = 0, `rts_n` is the inverse of `rts_request` whatever the occupancy. With `flow_auto` = 1 and `rts_request` = 0, `rts_n` is high.
- R12: `trig_sel` encodes the threshold as 00 = 1, 01 = 4, 10 = 8 and 11 = 14 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| serial_in | input | 1 | Serial receive line, idle high |
| char_len | input | 2 | Data bit count select (5 to 8) |
| parity_en | input | 1 | Expect a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| flow_auto | input | 1 | Enable automatic flow control |
| rts_request | input | 1 | Host request-to-send bit |
| trig_sel | input | 2 | Flow-control threshold select |
| pop | input | 1 | Remove the head entry |
| status_rd | input | 1 | Clear the overrun flag |
| rx_data | output | 8 | Head entry data |
| rx_perr | output | 1 | Head entry parity error |
| rx_ferr | output | 1 | Head entry framing error |
| rx_brk | output | 1 | Head entry break |
| rx_level | output | 5 | Number of entries held |
| overrun | output | 1 | Sticky overrun flag |
| rts_n | output | 1 | Request to send, active low |

## Verification
The embedded properties assume that `baud_tick` pulses are at least two clocks apart. With that spacing a finished character cannot write twice in consecutive cycles. They also assume that `trig_sel` does not change while a threshold decision is pending. The stimulus spaces the ticks four clocks apart. It changes the format, threshold and flow settings only while the line is idle, and each serial bit lasts exactly sixteen ticks. Pops and status reads are single-cycle strobes driven between clock edges, and each pop is followed by a short settling wait so that the registered request-to-send decision can take effect.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_WAITHI
   } rx_state_e;

   typedef struct packed {
      logic brk;
      logic ferr;
      logic perr;
   } rx_flags_t;

   localparam int FLAG_W = 3;

   // threshold in entries for a 2-bit select, scaled to the queue depth
   function automatic int trig_count(input logic [1:0] sel, input int depth);
      case (sel)
         2'd0:    return 1;
         2'd1:    return depth / 4;
         2'd2:    return depth / 2;
         default: return depth - 2;
      endcase
   endfunction

endpackage

// File: rtl/rxq_sampler.sv
module rxq_sampler
   import rxq_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OS_RATE     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              serial_in,
   input  logic [1:0]        char_len,
   input  logic              parity_en,
   input  logic              parity_odd,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output rx_flags_t         push_flags,
   output logic              first_bit
);

   localparam int CNT_W = $clog2(OS_RATE);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OS_RATE / 2 - 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OS_RATE - 1);
   localparam logic [IDX_W-1:0] MIN_LAST = IDX_W'(DATA_W - 4);

   if (OS_RATE < 4 || (OS_RATE & (OS_RATE - 1)) != 0) begin : g_bad_os
      $error("OS_RATE must be a power of two, at least 4");
   end
   if (DATA_W < 5) begin : g_bad_w
      $error("DATA_W must be at least 5");
   end

   logic rx_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = serial_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sr <= '1;
         end else begin
            sr[0] <= serial_in;
            for (int k = 1; k < SYNC_STAGES; k++) sr[k] <= sr[k-1];
         end
      end
      assign rx_s = sr[SYNC_STAGES-1];
   end

   rx_state_e         st;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] shreg;
   logic              pbit;
   logic [IDX_W-1:0]  last_idx;
   logic              bit_due;
   logic              par_bad;
   logic              is_break;

   assign last_idx = MIN_LAST + IDX_W'(char_len);
   assign bit_due  = (cnt == LAST_CNT);
   assign par_bad  = parity_en & (^shreg ^ pbit ^ parity_odd);
   assign is_break = (shreg == '0) & (~parity_en | ~pbit) & ~rx_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= RX_IDLE;
         cnt        <= '0;
         idx        <= '0;
         shreg      <= '0;
         pbit       <= 1'b0;
         push       <= 1'b0;
         push_data  <= '0;
         push_flags <= '0;
         first_bit  <= 1'b0;
      end else begin
         push      <= 1'b0;
         first_bit <= 1'b0;
         if (baud_tick) begin
            case (st)
               RX_IDLE: begin
                  cnt <= '0;
                  if (!rx_s) st <= RX_START;
               end
               RX_START: begin
                  if (cnt == MID_CNT) begin
                     cnt   <= '0;
                     idx   <= '0;
                     shreg <= '0;
                     pbit  <= 1'b0;
                     st    <= rx_s ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               RX_DATA: begin
                  cnt <= cnt + CNT_W'(1);
                  if (bit_due) begin
                     shreg[idx] <= rx_s;
                     first_bit  <= (idx == '0);
                     idx        <= idx + IDX_W'(1);
                     if (idx == last_idx) st <= parity_en ? RX_PAR : RX_STOP;
                  end
               end
               RX_PAR: begin
                  cnt <= cnt + CNT_W'(1);
                  if (bit_due) begin
                     pbit <= rx_s;
                     st   <= RX_STOP;
                  end
               end
               RX_STOP: begin
                  cnt <= cnt + CNT_W'(1);
                  if (bit_due) begin
                     push            <= 1'b1;
                     push_data       <= shreg;
                     push_flags.perr <= par_bad;
                     push_flags.ferr <= ~rx_s;
                     push_flags.brk  <= is_break;
                     st              <= rx_s ? RX_IDLE : RX_WAITHI;
                  end
               end
               RX_WAITHI: begin
                  cnt <= '0;
                  if (rx_s) st <= RX_IDLE;
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

   // R2
   push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !push);

   // R5
   brk_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && push_flags.brk) |-> push_flags.ferr);

   // R5
   waithi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_WAITHI && !rx_s) |=> (st == RX_WAITHI));

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
   parameter int ENT_W = 11,
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [ENT_W-1:0]           push_ent,
   input  logic                       pop,
   input  logic                       status_rd,
   output logic [ENT_W-1:0]           head_ent,
   output logic [$clog2(DEPTH):0]     level,
   output logic                       pop_ok,
   output logic                       overrun
);

   localparam int ADDR_W = $clog2(DEPTH);
   localparam int LVL_W  = ADDR_W + 1;
   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 16) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 16");
   end

   logic [ENT_W-1:0]  mem [DEPTH];
   logic [ADDR_W-1:0] wptr, rptr;
   logic              full, empty, push_ok;

   assign full     = (level == FULL_LVL);
   assign empty    = (level == '0);
   assign push_ok  = push & ~full;
   assign pop_ok   = pop & ~empty;
   assign head_ent = mem[rptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= push_ent;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         level   <= '0;
         overrun <= 1'b0;
      end else begin
         if (push_ok) wptr <= wptr + ADDR_W'(1);
         if (pop_ok)  rptr <= rptr + ADDR_W'(1);
         case ({push_ok, pop_ok})
            2'b10:   level <= level + LVL_W'(1);
            2'b01:   level <= level - LVL_W'(1);
            default: level <= level;
         endcase
         if (push && full)   overrun <= 1'b1;
         else if (status_rd) overrun <= 1'b0;
      end
   end

   // R7
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= FULL_LVL);

   // R7
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && level == '0 && !push) |=> (level == '0));

   // R8
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && level == FULL_LVL) |=> overrun);

   // R8
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && level == FULL_LVL) |=> (level == FULL_LVL));

endmodule

// File: rtl/rxq_rts_ctl.sv
module rxq_rts_ctl
   import rxq_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             trig_sel,
   input  logic                   flow_auto,
   input  logic                   rts_request,
   input  logic [$clog2(DEPTH):0] level,
   input  logic                   pop_ok,
   input  logic                   first_bit,
   output logic                   rts_n
);

   localparam int LVL_W = $clog2(DEPTH) + 1;
   localparam logic [LVL_W-1:0] NEAR_FULL = LVL_W'(DEPTH - 1);

   logic [LVL_W-1:0] trig_lvl;
   logic             top_mode;
   logic             hold;

   assign trig_lvl = LVL_W'(trig_count(trig_sel, DEPTH));
   assign top_mode = (trig_sel == 2'b11);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold <= 1'b0;
      end else if (top_mode) begin
         if (first_bit && level >= NEAR_FULL) hold <= 1'b1;
         else if (pop_ok || level == '0)     hold <= 1'b0;
      end else begin
         if (level >= trig_lvl)  hold <= 1'b1;
         else if (level == '0)   hold <= 1'b0;
      end
   end

   assign rts_n = flow_auto ? ~(rts_request & ~hold) : ~rts_request;

   // R9
   low_trig_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!top_mode && level >= trig_lvl) |=> (rts_n || !flow_auto || !rts_request));

   // R9
   low_trig_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !top_mode && level != '0) |=> hold);

   // R10
   top_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (top_mode && pop_ok && !first_bit) |=> !hold);

   // R10
   top_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (top_mode && first_bit && level >= NEAR_FULL) |=> (rts_n || !flow_auto || !rts_request));

endmodule

// File: rtl/uart_rx_rtsq.sv
module uart_rx_rtsq
   import rxq_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 16,
   parameter int OS_RATE     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   baud_tick,
   input  logic                   serial_in,
   input  logic [1:0]             char_len,
   input  logic                   parity_en,
   input  logic                   parity_odd,
   input  logic                   flow_auto,
   input  logic                   rts_request,
   input  logic [1:0]             trig_sel,
   input  logic                   pop,
   input  logic                   status_rd,
   output logic [DATA_W-1:0]      rx_data,
   output logic                   rx_perr,
   output logic                   rx_ferr,
   output logic                   rx_brk,
   output logic [$clog2(DEPTH):0] rx_level,
   output logic                   overrun,
   output logic                   rts_n
);

   localparam int ENT_W = DATA_W + FLAG_W;

   logic              push, first_bit, pop_ok;
   logic [DATA_W-1:0] push_data;
   rx_flags_t         push_flags, head_flags;
   logic [ENT_W-1:0]  head_ent;

   rxq_sampler #(
      .DATA_W(DATA_W), .OS_RATE(OS_RATE), .SYNC_STAGES(SYNC_STAGES)
   ) u_sampler (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .serial_in(serial_in),
      .char_len(char_len), .parity_en(parity_en), .parity_odd(parity_odd),
      .push(push), .push_data(push_data), .push_flags(push_flags),
      .first_bit(first_bit)
   );

   rxq_fifo #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .push_ent({push_flags, push_data}),
      .pop(pop), .status_rd(status_rd), .head_ent(head_ent), .level(rx_level),
      .pop_ok(pop_ok), .overrun(overrun)
   );

   rxq_rts_ctl #(.DEPTH(DEPTH)) u_rts (
      .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .flow_auto(flow_auto),
      .rts_request(rts_request), .level(rx_level), .pop_ok(pop_ok),
      .first_bit(first_bit), .rts_n(rts_n)
   );

   assign rx_data    = head_ent[DATA_W-1:0];
   assign head_flags = head_ent[ENT_W-1:DATA_W];
   assign rx_perr    = head_flags.perr;
   assign rx_ferr    = head_flags.ferr;
   assign rx_brk     = head_flags.brk;

endmodule

// File: tb/uart_rx_rtsq_test.sv
module uart_rx_rtsq_test;

   localparam int BIT_CLK = 64;
   localparam int WD_CYC  = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       serial_in = 1'b1;
   logic [1:0] char_len = 2'b11;
   logic       parity_en = 1'b0;
   logic       parity_odd = 1'b0;
   logic       flow_auto = 1'b1;
   logic       rts_request = 1'b1;
   logic [1:0] trig_sel = 2'b11;
   logic       pop = 1'b0;
   logic       status_rd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_perr, rx_ferr, rx_brk;
   logic [4:0] rx_level;
   logic       overrun, rts_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   uart_rx_rtsq uut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .serial_in(serial_in),
      .char_len(char_len), .parity_en(parity_en), .parity_odd(parity_odd),
      .flow_auto(flow_auto), .rts_request(rts_request), .trig_sel(trig_sel),
      .pop(pop), .status_rd(status_rd), .rx_data(rx_data), .rx_perr(rx_perr),
      .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_level(rx_level),
      .overrun(overrun), .rts_n(rts_n)
   );

   always #2 clk = ~clk;

   initial begin
      forever begin
         @(negedge clk) baud_tick = 1'b1;
         @(negedge clk) baud_tick = 1'b0;
         repeat (2) @(negedge clk);
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive_bit(input logic b);
      serial_in = b;
      repeat (BIT_CLK) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] d, input int nb, input bit bad_par,
                            input logic stop_v);
      logic [7:0] dm;
      dm = d & 8'((1 << nb) - 1);
      drive_bit(1'b0);
      for (int i = 0; i < nb; i++) drive_bit(dm[i]);
      if (parity_en) drive_bit((^dm) ^ parity_odd ^ bad_par);
      drive_bit(stop_v);
      drive_bit(1'b1);
   endtask

   task automatic do_pop();
      @(negedge clk) pop = 1'b1;
      @(negedge clk) pop = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic expect_head(input logic [7:0] d, input logic [2:0] fl, input string tag);
      chk(rx_data == d, tag, rx_data, d);
      chk({rx_brk, rx_ferr, rx_perr} == fl, tag, {rx_brk, rx_ferr, rx_perr}, fl);
      do_pop();
   endtask

   task automatic t_reset();
      chk(rx_level == 0, "R1 level", rx_level, 0);
      chk(overrun == 1'b0, "R1 overrun", overrun, 0);
      chk(rts_n == 1'b0, "R1 rts_n", rts_n, 0);
   endtask

   task automatic t_format();
      trig_sel = 2'b11;
      char_len = 2'b11; send_char(8'hA5, 8, 0, 1'b1);
      expect_head(8'hA5, 3'b000, "R2 8-bit");
      char_len = 2'b00; send_char(8'hF6, 5, 0, 1'b1);
      expect_head(8'h16, 3'b000, "R2 5-bit");
      char_len = 2'b01; send_char(8'hE9, 6, 0, 1'b1);
      expect_head(8'h29, 3'b000, "R2 6-bit");
      char_len = 2'b10; send_char(8'hD3, 7, 0, 1'b1);
      expect_head(8'h53, 3'b000, "R2 7-bit");
      char_len = 2'b11;
   endtask

   task automatic t_parity();
      parity_en = 1'b1;
      parity_odd = 1'b0; send_char(8'h37, 8, 0, 1'b1);
      expect_head(8'h37, 3'b000, "R3 even ok");
      parity_odd = 1'b1; send_char(8'h37, 8, 0, 1'b1);
      expect_head(8'h37, 3'b000, "R3 odd ok");
      parity_odd = 1'b0; send_char(8'h81, 8, 1, 1'b1);
      expect_head(8'h81, 3'b001, "R3 even bad");
      parity_odd = 1'b1; send_char(8'h80, 8, 1, 1'b1);
      expect_head(8'h80, 3'b001, "R3 odd bad");
      parity_en = 1'b0;
   endtask

   task automatic t_frame();
      send_char(8'h5C, 8, 0, 1'b0);
      expect_head(8'h5C, 3'b010, "R4 framing");
   endtask

   task automatic t_break();
      for (int i = 0; i < 14; i++) drive_bit(1'b0);
      drive_bit(1'b1);
      drive_bit(1'b1);
      chk(rx_level == 1, "R5 single entry", rx_level, 1);
      expect_head(8'h00, 3'b110, "R5 break");
   endtask

   task automatic t_false_start();
      serial_in = 1'b0;
      repeat (20) @(negedge clk);
      serial_in = 1'b1;
      repeat (4 * BIT_CLK) @(negedge clk);
      chk(rx_level == 0, "R6 false start", rx_level, 0);
      send_char(8'h3C, 8, 0, 1'b1);
      expect_head(8'h3C, 3'b000, "R6 recovery");
   endtask

   task automatic t_low_trig();
      trig_sel = 2'b01;
      for (int i = 0; i < 3; i++) send_char(8'(8'h40 + i), 8, 0, 1'b1);
      chk(rts_n == 1'b0, "R9 below 4", rts_n, 0);
      send_char(8'h43, 8, 0, 1'b1);
      chk(rts_n == 1'b1, "R12 at 4", rts_n, 1);
      for (int i = 0; i < 3; i++) do_pop();
      chk(rts_n == 1'b1, "R9 not empty", rts_n, 1);
      do_pop();
      chk(rts_n == 1'b0, "R9 empty", rts_n, 0);
      trig_sel = 2'b00;
      send_char(8'h11, 8, 0, 1'b1);
      chk(rts_n == 1'b1, "R12 at 1", rts_n, 1);
      do_pop();
      chk(rts_n == 1'b0, "R9 release 1", rts_n, 0);
      trig_sel = 2'b10;
      for (int i = 0; i < 7; i++) send_char(8'(8'h20 + i), 8, 0, 1'b1);
      chk(rts_n == 1'b0, "R12 below 8", rts_n, 0);
      send_char(8'h27, 8, 0, 1'b1);
      chk(rts_n == 1'b1, "R12 at 8", rts_n, 1);
      for (int i = 0; i < 8; i++) do_pop();
      chk(rts_n == 1'b0, "R9 release 8", rts_n, 0);
   endtask

   task automatic t_top_trig();
      logic [7:0] d16;
      trig_sel = 2'b11;
      for (int i = 0; i < 15; i++) send_char(8'(8'h30 + i), 8, 0, 1'b1);
      chk(rx_level == 15, "R7 level 15", rx_level, 15);
      chk(rts_n == 1'b0, "R10 at 15", rts_n, 0);
      d16 = 8'h3F;
      drive_bit(1'b0);
      drive_bit(d16[0]);
      chk(rts_n == 1'b1, "R10 mid char", rts_n, 1);
      for (int i = 1; i < 8; i++) drive_bit(d16[i]);
      drive_bit(1'b1);
      drive_bit(1'b1);
      chk(rx_level == 16, "R7 full", rx_level, 16);
      chk(overrun == 1'b0, "R8 no overrun yet", overrun, 0);
      send_char(8'h99, 8, 0, 1'b1);
      chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
      chk(rx_level == 16, "R8 dropped", rx_level, 16);
      chk(rx_data == 8'h30, "R7 head", rx_data, 8'h30);
      do_pop();
      chk(rts_n == 1'b0, "R10 release", rts_n, 0);
      chk(overrun == 1'b1, "R8 sticky", overrun, 1);
      @(negedge clk) status_rd = 1'b1;
      @(negedge clk) status_rd = 1'b0;
      chk(overrun == 1'b0, "R8 cleared", overrun, 0);
      for (int i = 1; i < 16; i++) expect_head(8'(8'h30 + i), 3'b000, "R7 order");
      @(negedge clk) pop = 1'b1;
      @(negedge clk) pop = 1'b0;
      chk(rx_level == 0, "R7 empty pop", rx_level, 0);
   endtask

   task automatic t_manual();
      trig_sel = 2'b00;
      flow_auto = 1'b0;
      send_char(8'h66, 8, 0, 1'b1);
      chk(rts_n == 1'b0, "R11 manual on", rts_n, 0);
      rts_request = 1'b0;
      @(negedge clk);
      chk(rts_n == 1'b1, "R11 manual off", rts_n, 1);
      flow_auto = 1'b1;
      do_pop();
      chk(rts_n == 1'b1, "R11 auto req0", rts_n, 1);
      rts_request = 1'b1;
      @(negedge clk);
      chk(rts_n == 1'b0, "R11 auto req1", rts_n, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_format();
      t_parity();
      t_frame();
      t_break();
      t_false_start();
      t_low_trig();
      t_top_trig();
      t_manual();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule